// File: doc/BRIEF.md
# Sector Buffer Transfer Engine

This block moves decoded sector bytes out of a byte-wide sector buffer. It works in one of two ways. In the first, a burst DMA writes 16-bit words into program RAM or word RAM. In the second, a main or sub processor pulls the data one word per read request. Two counters track the transfer: a 16-bit data address pointer into the buffer and a remaining-byte counter. Each word is built big-endian from two buffer bytes. When the last byte has been handed over, the block raises the completion flags and, if enabled, an interrupt.

Software loads the two counters with a start pulse while transfers are enabled. It selects the destination with a 3-bit field. The DMA path is driven one chunk at a time: each pulse on `chunk_start_i` moves at most 256 words, and the block answers with a single `chunk_done_o` pulse.

The controller has these states:
- `ST_IDLE`: waits for a start, a chunk request or a host read, in that priority.
- DMA path: `ST_DMA_HI` fetches the high byte, `ST_DMA_LO` fetches the low byte, `ST_DMA_WR` writes the word, and `ST_DMA_DONE` closes the chunk.
- Host path: `ST_HOST_HI`, `ST_HOST_LO`, then `ST_HOST_ACK` returns the word.

The transitions are:
- Idle to DMA high: a qualified chunk request with a non-zero word count.
- Idle to DMA done: a zero-word chunk.
- DMA write back to DMA high: more words remain.
- DMA write to DMA done: the word just written was the last of the chunk.
- Idle to host high: a valid host read.
- Idle to host ack: an invalid host read.
- DMA done or host ack back to idle.

Top module: `sector_xfer_engine`

## Requirements
- R1: A chunk request when the byte counter is at most 512 moves (count+1)>>1 words and is the last chunk, so a count of 0 moves no words. Any larger count moves exactly 256 words.
- R2: Every destination word carries the buffer byte at the data address in bits 15:8 and the byte at the next address in bits 7:0.
- R3: With destination field 5 (program RAM, `dst_wram_o`=0), word k of a chunk goes to byte address (DMA address << 3) + 2k, modulo 2^19.
- R4: With destination field 7 and `wram_1m_i`=0 (word RAM, `dst_wram_o`=1), word k goes to byte address ((DMA address & 0x7FFF) << 3) + 2k.
- R5: With destination field 7 and `wram_1m_i`=1, word k goes to byte address ((DMA address & 0x3FFF) << 4) + 4k, plus 2 when `wram_bank_i` is 0.
- R6: After a chunk of n words, the data address advances by 2n modulo 65536. The byte counter drops by 2n if the transfer is still active and not on its last chunk; otherwise it becomes 0.
- R7: A host read returns 0 and changes no counter unless a transfer is active and the destination field equals 2 (with `host_sub_i`=0) or 3 (with `host_sub_i`=1).
- R8: A valid host read returns the word at the data address, advances the address by 2 and lowers the counter by 2. If the counter was 2 or less, it becomes 0 and the transfer ends.
- R9: Ending a transfer does four things: `active_o` goes low, `end_flag_o` goes high, `data_ready_o` goes low and `idle_o` goes high. A start with transfers enabled reverses all four.
- R10: At the end, if `dte_ien_i` is 1, `irq_n_o` goes low, and `irq_req_o` pulses for one cycle when `irq_mask_i` is also 1. `irq_ack_i` returns `irq_n_o` to 1.
- R11: `chunk_start_i` is ignored (no write, no done pulse, no counter change) unless the transfer is active and the destination field is 5 or 7. Each accepted chunk gives exactly one `chunk_done_o` pulse.
- R12: Dropping `xfer_en_i` while active clears `active_o`, sets `idle_o` and zeroes the byte counter. A start while `xfer_en_i` is 0 loads the counters but does not activate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en_i | input | 1 | Transfer enable; low aborts an active transfer |
| start_i | input | 1 | Load counters and start (if enabled) |
| dac_load_i | input | 16 | Data address loaded at start |
| dbc_load_i | input | 16 | Byte count loaded at start |
| dest_sel_i | input | 3 | Destination field: 2 main host, 3 sub host, 5 program RAM, 7 word RAM |
| dma_addr_i | input | 16 | DMA destination address |
| wram_1m_i | input | 1 | Word RAM split (1M) mode |
| wram_bank_i | input | 1 | Word RAM bank select in 1M mode |
| chunk_start_i | input | 1 | Request one DMA chunk |
| chunk_done_o | output | 1 | One-cycle pulse at the end of an accepted chunk |
| host_rd_i | input | 1 | Host word read request |
| host_sub_i | input | 1 | Read comes from the sub processor |
| host_ack_o | output | 1 | Host read answer strobe |
| host_data_o | output | 16 | Host read data |
| buf_addr_o | output | 16 | Sector buffer byte address |
| buf_rdata_i | input | 8 | Buffer byte, one cycle after the address |
| dst_we_o | output | 1 | Destination write strobe |
| dst_wram_o | output | 1 | Write goes to word RAM (else program RAM) |
| dst_addr_o | output | 19 | Destination byte address |
| dst_wdata_o | output | 16 | Destination word |
| dte_ien_i | input | 1 | End-of-transfer interrupt enable |
| irq_mask_i | input | 1 | Interrupt level mask bit |
| irq_ack_i | input | 1 | Clear the pending end interrupt |
| active_o | output | 1 | Transfer in progress |
| end_flag_o | output | 1 | Transfer-ended flag |
| data_ready_o | output | 1 | Data-ready flag |
| idle_o | output | 1 | No transfer in progress (status) |
| irq_n_o | output | 1 | Active-low pending end interrupt |
| irq_req_o | output | 1 | Interrupt request pulse |
| dac_o | output | 16 | Data address counter |
| dbc_o | output | 16 | Remaining byte counter |

## Verification
The hardest case to reach is a transfer that crosses several chunk boundaries and also takes host reads between chunks. That same transfer has to wrap the data address past 0xFFFF and finish on an odd count. The case matters because the last-chunk rule and the host clamp then interact on the same counter.

The stimulus loads counts above 1024 for full-size chunks. Starting addresses just below 0xFFFF and odd counts force the wrap and the rounding. Random runs interleave host reads and chunks with random destination fields and memory modes until the transfer ends, and the bench model tracks every counter, flag and interrupt.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
    typedef enum logic [1:0] {
        DST_PRG   = 2'd0,
        DST_W2M   = 2'd1,
        DST_W1M   = 2'd2
    } dst_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DMA_HI,
        ST_DMA_LO,
        ST_DMA_WR,
        ST_DMA_DONE,
        ST_HOST_HI,
        ST_HOST_LO,
        ST_HOST_ACK
    } xfer_state_e;

    localparam logic [2:0] DSEL_MAIN = 3'd2;
    localparam logic [2:0] DSEL_SUB  = 3'd3;
    localparam logic [2:0] DSEL_PRG  = 3'd5;
    localparam logic [2:0] DSEL_WRAM = 3'd7;
endpackage

// File: rtl/sxe_chunk_calc.sv
module sxe_chunk_calc #(
    parameter int CNT_W       = 16,
    parameter int CHUNK_WORDS = 256,
    parameter int WCNT_W      = 9
) (
    input  logic [CNT_W-1:0]  remain_i,
    output logic [WCNT_W-1:0] words_o,
    output logic              last_o
);
    localparam int CHUNK_BYTES = 2 * CHUNK_WORDS;
    localparam logic [CNT_W:0] LIMIT = (CNT_W+1)'(CHUNK_BYTES);
    localparam logic [WCNT_W-1:0] FULL = WCNT_W'(CHUNK_WORDS);

    logic [CNT_W:0] ext;
    logic [CNT_W:0] half;

    always_comb begin
        ext     = {1'b0, remain_i};
        half    = (ext + (CNT_W+1)'(1)) >> 1;
        last_o  = (ext <= LIMIT);
        words_o = last_o ? half[WCNT_W-1:0] : FULL;
    end
endmodule

// File: rtl/sxe_addr_gen.sv
module sxe_addr_gen
    import sxe_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WCNT_W = 9
) (
    input  dst_mode_e              mode_i,
    input  logic [ADDR_W-1:0]      dma_addr_i,
    input  logic                   bank_i,
    input  logic [WCNT_W-1:0]      idx_i,
    output logic [ADDR_W+2:0]      addr_o
);
    localparam int DADDR_W = ADDR_W + 3;

    logic [DADDR_W-1:0] base;
    logic [DADDR_W-1:0] offs;

    always_comb begin
        unique case (mode_i)
            DST_W2M: begin
                base = {1'b0, dma_addr_i[ADDR_W-2:0], 3'b000};
                offs = DADDR_W'({idx_i, 1'b0});
            end
            DST_W1M: begin
                // interleaved halves: 4-byte stride, odd word slot for bank 0
                base = {1'b0, dma_addr_i[ADDR_W-3:0], 4'b0000}
                     + {{(DADDR_W-2){1'b0}}, ~bank_i, 1'b0};
                offs = DADDR_W'({idx_i, 2'b00});
            end
            default: begin
                base = {dma_addr_i, 3'b000};
                offs = DADDR_W'({idx_i, 1'b0});
            end
        endcase
        addr_o = base + offs;
    end
endmodule

// File: rtl/sxe_status.sv
module sxe_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start_evt_i,
    input  logic end_evt_i,
    input  logic stop_evt_i,
    input  logic dte_ien_i,
    input  logic irq_mask_i,
    input  logic irq_ack_i,
    output logic active_o,
    output logic end_flag_o,
    output logic ready_o,
    output logic idle_o,
    output logic irq_n_o,
    output logic irq_req_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_o   <= 1'b0;
            end_flag_o <= 1'b0;
            ready_o    <= 1'b0;
            idle_o     <= 1'b1;
            irq_n_o    <= 1'b1;
            irq_req_o  <= 1'b0;
        end else begin
            irq_req_o <= end_evt_i & dte_ien_i & irq_mask_i;
            if (irq_ack_i)
                irq_n_o <= 1'b1;
            if (end_evt_i) begin
                active_o   <= 1'b0;
                end_flag_o <= 1'b1;
                ready_o    <= 1'b0;
                idle_o     <= 1'b1;
                if (dte_ien_i)
                    irq_n_o <= 1'b0;
            end else if (stop_evt_i) begin
                active_o <= 1'b0;
                idle_o   <= 1'b1;
            end else if (start_evt_i) begin
                active_o   <= 1'b1;
                end_flag_o <= 1'b0;
                ready_o    <= 1'b1;
                idle_o     <= 1'b0;
            end
        end
    end

    // R9
    end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt_i |=> (!active_o && end_flag_o && !ready_o && idle_o));

    // R10
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> !irq_n_o);

    // R12
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt_i && !end_evt_i) |=> (!active_o && idle_o));
endmodule

// File: rtl/sector_xfer_engine.sv
module sector_xfer_engine
    import sxe_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    parameter int CHUNK_WORDS = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_en_i,
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   dac_load_i,
    input  logic [CNT_W-1:0]    dbc_load_i,
    input  logic [2:0]          dest_sel_i,
    input  logic [ADDR_W-1:0]   dma_addr_i,
    input  logic                wram_1m_i,
    input  logic                wram_bank_i,
    input  logic                chunk_start_i,
    output logic                chunk_done_o,
    input  logic                host_rd_i,
    input  logic                host_sub_i,
    output logic                host_ack_o,
    output logic [15:0]         host_data_o,
    output logic [ADDR_W-1:0]   buf_addr_o,
    input  logic [7:0]          buf_rdata_i,
    output logic                dst_we_o,
    output logic                dst_wram_o,
    output logic [ADDR_W+2:0]   dst_addr_o,
    output logic [15:0]         dst_wdata_o,
    input  logic                dte_ien_i,
    input  logic                irq_mask_i,
    input  logic                irq_ack_i,
    output logic                active_o,
    output logic                end_flag_o,
    output logic                data_ready_o,
    output logic                idle_o,
    output logic                irq_n_o,
    output logic                irq_req_o,
    output logic [ADDR_W-1:0]   dac_o,
    output logic [CNT_W-1:0]    dbc_o
);
    localparam int WCNT_W = $clog2(CHUNK_WORDS + 1);

    xfer_state_e state_q, state_d;

    logic [ADDR_W-1:0] dac_q;
    logic [CNT_W-1:0]  dbc_q;
    logic [WCNT_W-1:0] words_q, idx_q, calc_words;
    logic              last_q, calc_last;
    dst_mode_e         mode_q, sel_mode;
    logic [ADDR_W-1:0] dma_q;
    logic              bank_q;
    logic [7:0]        hi_q;
    logic              hvalid_q;

    logic chunk_go, host_ok, start_evt, end_evt, stop_evt;

    sxe_chunk_calc #(.CNT_W(CNT_W), .CHUNK_WORDS(CHUNK_WORDS), .WCNT_W(WCNT_W)) calc_i (
        .remain_i (dbc_q),
        .words_o  (calc_words),
        .last_o   (calc_last)
    );

    sxe_addr_gen #(.ADDR_W(ADDR_W), .WCNT_W(WCNT_W)) agen_i (
        .mode_i     (mode_q),
        .dma_addr_i (dma_q),
        .bank_i     (bank_q),
        .idx_i      (idx_q),
        .addr_o     (dst_addr_o)
    );

    sxe_status status_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt_i (start_evt),
        .end_evt_i   (end_evt),
        .stop_evt_i  (stop_evt),
        .dte_ien_i   (dte_ien_i),
        .irq_mask_i  (irq_mask_i),
        .irq_ack_i   (irq_ack_i),
        .active_o    (active_o),
        .end_flag_o  (end_flag_o),
        .ready_o     (data_ready_o),
        .idle_o      (idle_o),
        .irq_n_o     (irq_n_o),
        .irq_req_o   (irq_req_o)
    );

    // request qualification
    always_comb begin
        chunk_go  = chunk_start_i && active_o &&
                    (dest_sel_i == DSEL_PRG || dest_sel_i == DSEL_WRAM);
        host_ok   = active_o && (dest_sel_i == (host_sub_i ? DSEL_SUB : DSEL_MAIN));
        sel_mode  = (dest_sel_i == DSEL_PRG) ? DST_PRG : (wram_1m_i ? DST_W1M : DST_W2M);
        start_evt = (state_q == ST_IDLE) && start_i && xfer_en_i;
        stop_evt  = active_o && !xfer_en_i;
        end_evt   = active_o &&
                    (((state_q == ST_DMA_DONE) && last_q) ||
                     ((state_q == ST_HOST_ACK) && hvalid_q && (dbc_q <= CNT_W'(2))));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i)
                    state_d = ST_IDLE;
                else if (chunk_go)
                    state_d = (calc_words == '0) ? ST_DMA_DONE : ST_DMA_HI;
                else if (host_rd_i)
                    state_d = host_ok ? ST_HOST_HI : ST_HOST_ACK;
            end
            ST_DMA_HI:   state_d = ST_DMA_LO;
            ST_DMA_LO:   state_d = ST_DMA_WR;
            ST_DMA_WR:   state_d = (idx_q + WCNT_W'(1) == words_q) ? ST_DMA_DONE : ST_DMA_HI;
            ST_DMA_DONE: state_d = ST_IDLE;
            ST_HOST_HI:  state_d = ST_HOST_LO;
            ST_HOST_LO:  state_d = ST_HOST_ACK;
            ST_HOST_ACK: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        buf_addr_o   = ((state_q == ST_DMA_LO) || (state_q == ST_HOST_LO))
                       ? dac_q + ADDR_W'(1) : dac_q;
        dst_we_o     = (state_q == ST_DMA_WR);
        dst_wram_o   = (mode_q != DST_PRG);
        dst_wdata_o  = {hi_q, buf_rdata_i};
        chunk_done_o = (state_q == ST_DMA_DONE);
        host_ack_o   = (state_q == ST_HOST_ACK);
        host_data_o  = (host_ack_o && hvalid_q) ? {hi_q, buf_rdata_i} : 16'h0000;
        dac_o        = dac_q;
        dbc_o        = dbc_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_q    <= '0;
            dbc_q    <= '0;
            words_q  <= '0;
            idx_q    <= '0;
            last_q   <= 1'b0;
            mode_q   <= DST_PRG;
            dma_q    <= '0;
            bank_q   <= 1'b0;
            hi_q     <= '0;
            hvalid_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dac_q <= dac_load_i;
                        dbc_q <= dbc_load_i;
                    end else if (chunk_go) begin
                        words_q <= calc_words;
                        last_q  <= calc_last;
                        mode_q  <= sel_mode;
                        dma_q   <= dma_addr_i;
                        bank_q  <= wram_bank_i;
                        idx_q   <= '0;
                    end else if (host_rd_i) begin
                        hvalid_q <= host_ok;
                    end
                end
                ST_DMA_LO, ST_HOST_LO: hi_q <= buf_rdata_i;
                ST_DMA_WR: begin
                    dac_q <= dac_q + ADDR_W'(2);
                    idx_q <= idx_q + WCNT_W'(1);
                end
                ST_DMA_DONE: begin
                    if (last_q || !active_o) dbc_q <= '0;
                    else                     dbc_q <= dbc_q - CNT_W'({words_q, 1'b0});
                end
                ST_HOST_ACK: begin
                    if (hvalid_q) begin
                        dac_q <= dac_q + ADDR_W'(2);
                        if (dbc_q <= CNT_W'(2)) dbc_q <= '0;
                        else                    dbc_q <= dbc_q - CNT_W'(2);
                    end
                end
                default: ;
            endcase
            if (stop_evt)
                dbc_q <= '0;
        end
    end

    // R11
    chunk_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_done_o |=> !chunk_done_o);

    // R1
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dst_we_o |-> (idx_q < words_q));

    // R6
    chunk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_done_o && (last_q || !active_o)) |=> (dbc_q == '0));

    // R8
    host_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack_o && hvalid_q) |=> (dac_q == $past(dac_q) + ADDR_W'(2)));

    // R7
    host_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack_o && !hvalid_q && !stop_evt) |=> ((dac_q == $past(dac_q)) && (dbc_q == $past(dbc_q))));
endmodule

// File: tb/sector_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module sector_xfer_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_en_i = 1'b1, start_i = 1'b0;
    logic [15:0] dac_load_i = '0, dbc_load_i = '0;
    logic [2:0]  dest_sel_i = '0;
    logic [15:0] dma_addr_i = '0;
    logic        wram_1m_i = 1'b0, wram_bank_i = 1'b0, chunk_start_i = 1'b0;
    logic        chunk_done_o, host_rd_i = 1'b0, host_sub_i = 1'b0, host_ack_o;
    logic [15:0] host_data_o, buf_addr_o;
    logic [7:0]  buf_rdata_i = '0;
    logic        dst_we_o, dst_wram_o;
    logic [18:0] dst_addr_o;
    logic [15:0] dst_wdata_o;
    logic        dte_ien_i = 1'b1, irq_mask_i = 1'b1, irq_ack_i = 1'b0;
    logic        active_o, end_flag_o, data_ready_o, idle_o, irq_n_o, irq_req_o;
    logic [15:0] dac_o, dbc_o;

    always #2 clk = ~clk;

    sector_xfer_engine dut_i (.*);

    int checks = 0, fails = 0;
    int m_dac = 0, m_dbc = 0, m_irqcnt = 0;
    bit m_active = 0, m_end = 0, m_ready = 0, m_idle = 1, m_irqn = 1;
    int irq_seen = 0, done_seen = 0;
    logic [15:0] mon_ptr = '0;
    logic [18:0] mon_base = '0;
    int mon_k = 0, mon_stride = 2;
    bit mon_wram = 0;
    string mon_req = "R3";

    function automatic logic [7:0] buf_byte(logic [15:0] a);
        return 8'((a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5);
    endfunction

    always @(posedge clk) buf_rdata_i <= buf_byte(buf_addr_o);

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && irq_req_o) irq_seen++;
        if (rst_n && chunk_done_o) done_seen++;
        if (rst_n && dst_we_o) begin
            logic [18:0] ea;
            logic [15:0] ed;
            ea = mon_base + 19'(mon_stride * mon_k);
            ed = {buf_byte(mon_ptr), buf_byte(mon_ptr + 16'd1)};
            chk(dst_wdata_o == ed, "R2", "word data", dst_wdata_o, ed);
            chk(dst_addr_o == ea, mon_req, "dest address", dst_addr_o, ea);
            chk(dst_wram_o == mon_wram, mon_req, "dest select", dst_wram_o, mon_wram);
            mon_ptr = mon_ptr + 16'd2;
            mon_k++;
        end
    end

    task automatic check_state(string req);
        chk(dac_o == 16'(m_dac), req, "dac", dac_o, m_dac);
        chk(dbc_o == 16'(m_dbc), req, "dbc", dbc_o, m_dbc);
        chk(active_o == m_active, req, "active", active_o, m_active);
        chk(end_flag_o == m_end, "R9", "end flag", end_flag_o, m_end);
        chk(data_ready_o == m_ready, "R9", "data ready", data_ready_o, m_ready);
        chk(idle_o == m_idle, "R9", "idle", idle_o, m_idle);
        chk(irq_n_o == m_irqn, "R10", "irq_n", irq_n_o, m_irqn);
        chk(irq_seen == m_irqcnt, "R10", "irq pulses", irq_seen, m_irqcnt);
    endtask

    task automatic model_end();
        m_active = 0; m_end = 1; m_ready = 0; m_idle = 1;
        if (dte_ien_i) m_irqn = 0;
        if (dte_ien_i && irq_mask_i) m_irqcnt++;
    endtask

    task automatic do_start(int dac, int dbc, bit en);
        @(posedge clk); #1;
        xfer_en_i = en; start_i = 1'b1;
        dac_load_i = 16'(dac); dbc_load_i = 16'(dbc);
        @(posedge clk); #1;
        start_i = 1'b0;
        m_dac = dac & 16'hFFFF; m_dbc = dbc & 16'hFFFF;
        if (en) begin m_active = 1; m_idle = 0; m_end = 0; m_ready = 1; end
        repeat (2) @(negedge clk);
        check_state(en ? "R9" : "R12");
        xfer_en_i = 1'b1;
    endtask

    task automatic do_chunk(int dest, int dma, bit m1, bit bank, string req);
        bit elig;
        int words, d0;
        bit last;
        elig = m_active && (dest == 5 || dest == 7);
        @(posedge clk); #1;
        dest_sel_i = 3'(dest); dma_addr_i = 16'(dma); wram_1m_i = m1; wram_bank_i = bank;
        mon_ptr = 16'(m_dac); mon_k = 0; mon_req = req;
        mon_wram = (dest == 7);
        if (dest == 7 && m1) begin
            mon_base = {1'b0, 16'(dma) & 16'h3FFF, 2'b00} + (bank ? 19'd0 : 19'd2);
            mon_base = {mon_base[16:0], 2'b00} + (bank ? 19'd0 : 19'd2);
            mon_base = 19'((dma & 32'h3FFF) << 4) + (bank ? 19'd0 : 19'd2);
            mon_stride = 4;
        end else if (dest == 7) begin
            mon_base = 19'((dma & 32'h7FFF) << 3); mon_stride = 2;
        end else begin
            mon_base = 19'((dma & 32'hFFFF) << 3); mon_stride = 2;
        end
        d0 = done_seen;
        chunk_start_i = 1'b1;
        @(posedge clk); #1;
        chunk_start_i = 1'b0;
        if (!elig) begin
            repeat (6) @(posedge clk);
            @(negedge clk);
            chk(done_seen == d0, "R11", "done on ignored chunk", done_seen - d0, 0);
            chk(mon_k == 0, "R11", "writes on ignored chunk", mon_k, 0);
            check_state("R11");
            return;
        end
        last  = (m_dbc <= 512);
        words = last ? (m_dbc + 1) >> 1 : 256;
        for (int t = 0; t < 5000; t++) begin
            @(negedge clk);
            if (done_seen != d0) break;
        end
        chk(mon_k == words, "R1", "words in chunk", mon_k, words);
        chk(done_seen - d0 == 1, "R11", "done pulses", done_seen - d0, 1);
        m_dac = (m_dac + 2 * words) & 16'hFFFF;
        if (last) begin m_dbc = 0; model_end(); end
        else m_dbc = m_dbc - 2 * words;
        repeat (2) @(negedge clk);
        check_state("R6");
    endtask

    task automatic do_host(bit sub, int dest, string req);
        bit valid;
        logic [15:0] got, exp;
        valid = m_active && (dest == (sub ? 3 : 2));
        got = 16'hDEAD;
        @(posedge clk); #1;
        dest_sel_i = 3'(dest); host_sub_i = sub; host_rd_i = 1'b1;
        @(posedge clk); #1;
        host_rd_i = 1'b0;
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (host_ack_o) begin got = host_data_o; break; end
        end
        exp = valid ? {buf_byte(16'(m_dac)), buf_byte(16'(m_dac + 1))} : 16'h0000;
        chk(got == exp, req, "host data", got, exp);
        if (valid) begin
            m_dac = (m_dac + 2) & 16'hFFFF;
            if (m_dbc <= 2) begin m_dbc = 0; model_end(); end
            else m_dbc = m_dbc - 2;
        end
        repeat (2) @(negedge clk);
        check_state(req);
    endtask

    task automatic do_ack();
        @(posedge clk); #1; irq_ack_i = 1'b1;
        @(posedge clk); #1; irq_ack_i = 1'b0;
        m_irqn = 1;
        @(negedge clk);
        check_state("R10");
    endtask

    task automatic do_abort();
        @(posedge clk); #1; xfer_en_i = 1'b0;
        if (m_active) begin m_active = 0; m_idle = 1; m_dbc = 0; end
        repeat (2) @(negedge clk);
        check_state("R12");
        xfer_en_i = 1'b1;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_state("R9");

        // multi-chunk transfer across all three address modes
        do_start(16'h0010, 1300, 1);
        do_chunk(5, 16'h1234, 0, 0, "R3");
        do_chunk(7, 16'h8ABC, 0, 0, "R4");
        do_chunk(7, 16'hC123, 1, 0, "R5");
        do_ack();
        do_chunk(5, 16'h0040, 0, 0, "R11");
        do_host(0, 2, "R7");

        // wrap of the data address with host reads and odd tail
        do_start(16'hFFF0, 41, 1);
        do_chunk(2, 16'h0001, 0, 0, "R11");
        do_host(1, 2, "R7");
        do_host(0, 3, "R7");
        do_host(0, 2, "R8");
        do_chunk(7, 16'h3FFF, 1, 1, "R5");
        do_ack();

        // host-only end without interrupt enable
        dte_ien_i = 1'b0;
        do_start(16'h0100, 4, 1);
        do_host(1, 3, "R8");
        do_host(1, 3, "R8");
        do_host(1, 3, "R7");
        dte_ien_i = 1'b1;

        // masked interrupt: pending but no request pulse
        irq_mask_i = 1'b0;
        do_start(16'h0500, 3, 1);
        do_chunk(5, 16'hFFFF, 0, 0, "R3");
        do_ack();
        irq_mask_i = 1'b1;

        // abort and disabled start
        do_start(16'h0200, 2000, 1);
        do_chunk(7, 16'h7777, 0, 0, "R4");
        do_abort();
        do_chunk(5, 16'h0000, 0, 0, "R11");
        do_start(16'h0AA0, 77, 0);
        do_chunk(5, 16'h0000, 0, 0, "R12");

        // zero count chunk
        do_start(16'h0300, 0, 1);
        do_chunk(5, 16'h0008, 0, 0, "R1");
        do_ack();

        // random transfers
        for (int it = 0; it < 25; it++) begin
            dte_ien_i  = 1'($urandom % 2);
            irq_mask_i = 1'($urandom % 2);
            do_start(int'($urandom % 65536), int'($urandom % 1500), 1);
            for (int s = 0; s < 40 && m_active; s++) begin
                int r, dsel;
                r = int'($urandom % 4);
                if (r == 0) begin
                    dsel = 2 + int'($urandom % 2);
                    do_host(1'($urandom % 2), dsel, "R8");
                end else begin
                    dsel = ($urandom % 3 == 0) ? 5 : 7;
                    do_chunk(dsel, int'($urandom % 65536), 1'($urandom % 2),
                             1'($urandom % 2), dsel == 5 ? "R3" : "R4");
                end
            end
            if (m_active) do_abort();
            if (!m_irqn) do_ack();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule